// File: doc/BRIEF.md
# Open-Row DRAM Bank Controller

This block sits between a requester and a small DRAM made of independent banks. It accepts one read or write request per cycle through a valid/ready handshake. It decodes the address into row, bank and column, and keeps a record of the row left open in every bank. Each request falls into one of three classes. A row hit needs only the column access. An access to an empty bank needs an activate first. A row conflict needs a precharge, then an activate, then the column access. The class sets how many cycles the bank stays busy before the response is returned.

The cell array itself lives outside the block. The controller presents the accepted address, write strobe and write data on a memory port in the cycle of acceptance. It captures the read data in that same cycle. It then holds the result in the bank until the class latency has elapsed. A simplified command bus reports the leading DRAM command for every accepted request, and it also reports the precharge-all and refresh commands of the refresh sequence.

A free-running interval counter marks a refresh as due. From that point no further request is taken. Once every bank has drained, the controller closes all rows with a precharge-all, waits out the precharge time, issues the refresh and waits out the refresh time. After that, intake resumes.

Top module: `dram_bank_ctrl`

## Requirements
- R1: The request address is split as {row, bank, column}, with the column in the least significant COL_W bits and the bank in the next BANK_W bits. An accepted request drives mem_en=1, mem_we=req_write and mem_addr=req_addr, and the bank field selects the bank state that is used.
- R2: A request whose row equals the open row of its bank is a hit. Its response appears T_CAS cycles after the accepting cycle, with rsp_hit=1. The command bus shows op 2 (read) or 3 (write) with that bank and row in the cycle after acceptance.
- R3: A request to a bank with no open row is an empty access. Its response appears T_RCD+T_CAS cycles after acceptance, with rsp_hit=0, and the command op is 1 (activate).
- R4: A request to a bank whose open row differs is a conflict. Its response appears T_RP+T_RCD+T_CAS cycles after acceptance, with rsp_hit=0, and the command op is 4 (precharge).
- R5: After any access, the accessed row stays open in its bank. A later request to the same row of that bank is a hit, unless a refresh has run in between.
- R6: Banks work independently. A request to an idle bank is accepted while other banks are still busy.
- R7: Requests are taken strictly in order. A request to a bank that is still busy, or that still holds an undelivered response, sees req_ready low and waits at the head of the input.
- R8: Every REF_PERIOD cycles a refresh becomes due and req_ready goes low. Once all banks are idle, op 5 (precharge all) appears on the command bus. Op 6 (refresh) follows T_RP cycles later. req_ready stays low until T_RFC cycles after the refresh command.
- R9: A refresh closes every bank, so the first request to any bank afterwards is an empty access.
- R10: If a refresh becomes due in the same cycle that a request to an idle bank is presented, the refresh wins and the request is not accepted.
- R11: When several banks hold finished responses at once, the lowest-numbered bank is delivered first and the rest follow in later cycles. There is one response per cycle.
- R12: A read returns the data of the latest earlier write to the same address, and a write responds with rsp_write=1 and rsp_rdata=0.
- R13: Under reset, req_ready is 1 and rsp_valid, cmd_valid and mem_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request will be taken at this edge |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ROW_W+BANK_W+COL_W | Address {row, bank, column} |
| req_wdata | input | DATA_W | Write data |
| mem_en | output | 1 | Cell array access this cycle |
| mem_we | output | 1 | Cell array write strobe |
| mem_addr | output | ROW_W+BANK_W+COL_W | Cell array address |
| mem_wdata | output | DATA_W | Cell array write data |
| mem_rdata | input | DATA_W | Cell array read data, combinational from mem_addr |
| cmd_valid | output | 1 | A command is shown on the command bus |
| cmd_op | output | 3 | 1 activate, 2 read, 3 write, 4 precharge, 5 precharge all, 6 refresh |
| cmd_bank | output | BANK_W | Bank of the command (0 for ops 5 and 6) |
| cmd_row | output | ROW_W | Row of the request (0 for ops 5 and 6) |
| rsp_valid | output | 1 | A response is delivered this cycle |
| rsp_bank | output | BANK_W | Bank the response comes from |
| rsp_write | output | 1 | Response completes a write |
| rsp_hit | output | 1 | The request was a row hit |
| rsp_rdata | output | DATA_W | Read data (0 for writes) |

## Verification
Two pairs of functions can land on the same cycle. The first pair is a refresh becoming due and a request arriving for an idle bank. The second is two banks finishing together, for example a conflict started a few cycles before a hit to a neighbouring bank. A long pseudo-random stream uses a narrow row range and a refresh interval short enough to hit both situations many times. The bench also counts how often each situation occurs and fails when one is never reached. A behavioural cycle model decides each time that the refresh takes the cycle and that the lower bank answers first, and every port is compared against it on every clock.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6
  } cmd_op_e;

  typedef enum logic [1:0] {
    ROW_HIT      = 2'd0,
    ROW_EMPTY    = 2'd1,
    ROW_CONFLICT = 2'd2
  } row_class_e;

  typedef enum logic [1:0] {
    RF_RUN = 2'd0,
    RF_PRE = 2'd1,
    RF_REF = 2'd2
  } rf_state_e;

endpackage

// File: rtl/dram_bank_slot.sv
module dram_bank_slot
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int DATA_W = 8,
  parameter int T_CAS  = 2,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [ROW_W-1:0]  acc_row,
  input  logic              acc_write,
  input  logic [DATA_W-1:0] acc_data,
  input  logic              close_all,
  input  logic              grant,
  output logic              busy,
  output logic              pend,
  output row_class_e        cls,
  output logic              hit_q,
  output logic              wr_q,
  output logic [DATA_W-1:0] data_q
);

  localparam int LAT_HIT   = T_CAS;
  localparam int LAT_EMPTY = T_RCD + T_CAS;
  localparam int LAT_CONF  = T_RP + T_RCD + T_CAS;
  localparam int CNT_W     = $clog2(LAT_CONF + 1);

  logic             open_vld_q, open_vld_n;
  logic [ROW_W-1:0] open_row_q, open_row_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             pend_q, pend_n;
  int               lat;

  always_comb begin
    if (!open_vld_q)                cls = ROW_EMPTY;
    else if (open_row_q == acc_row) cls = ROW_HIT;
    else                            cls = ROW_CONFLICT;
  end

  always_comb begin
    case (cls)
      ROW_HIT:   lat = LAT_HIT;
      ROW_EMPTY: lat = LAT_EMPTY;
      default:   lat = LAT_CONF;
    endcase
  end

  always_comb begin
    open_vld_n = open_vld_q;
    open_row_n = open_row_q;
    if (close_all) begin
      open_vld_n = 1'b0;
    end else if (acc) begin
      open_vld_n = 1'b1;
      open_row_n = acc_row;
    end

    if (acc)               cnt_n = (lat > 1) ? CNT_W'(lat - 1) : '0;
    else if (cnt_q != '0)  cnt_n = cnt_q - 1'b1;
    else                   cnt_n = cnt_q;

    pend_n = pend_q;
    if (grant) pend_n = 1'b0;
    if ((acc && lat == 1) || (cnt_q == CNT_W'(1))) pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_vld_q <= 1'b0;
      open_row_q <= '0;
      cnt_q      <= '0;
      pend_q     <= 1'b0;
      hit_q      <= 1'b0;
      wr_q       <= 1'b0;
      data_q     <= '0;
    end else begin
      open_vld_q <= open_vld_n;
      open_row_q <= open_row_n;
      cnt_q      <= cnt_n;
      pend_q     <= pend_n;
      if (acc) begin
        hit_q  <= (cls == ROW_HIT);
        wr_q   <= acc_write;
        data_q <= acc_data;
      end
    end
  end

  assign busy = (cnt_q != '0) || pend_q;
  assign pend = pend_q;

  // R7
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> !busy);

  // R11
  grant_only_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> pend_q);

  // R9
  close_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_all |-> (!busy && !acc));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ctrl_pkg::*;
#(
  parameter int REF_PERIOD = 120,
  parameter int T_RP       = 3,
  parameter int T_RFC      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic all_idle,
  output logic due,
  output logic active,
  output logic start,
  output logic issue_ref
);

  localparam int RC_W  = $clog2(REF_PERIOD);
  localparam int T_MAX = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int TC_W  = $clog2(T_MAX + 1);

  logic [RC_W-1:0] rcnt_q, rcnt_n;
  logic            due_q, due_n;
  rf_state_e       st_q, st_n;
  logic [TC_W-1:0] tcnt_q, tcnt_n;
  logic            wrap;

  assign wrap      = (rcnt_q == RC_W'(REF_PERIOD - 1));
  assign start     = (st_q == RF_RUN) && due_q && all_idle;
  assign issue_ref = (st_q == RF_PRE) && (tcnt_q == '0);

  always_comb begin
    rcnt_n = wrap ? '0 : rcnt_q + 1'b1;
    if (wrap)       due_n = 1'b1;
    else if (start) due_n = 1'b0;
    else            due_n = due_q;

    st_n   = st_q;
    tcnt_n = tcnt_q;
    case (st_q)
      RF_RUN: begin
        if (start) begin
          st_n   = RF_PRE;
          tcnt_n = TC_W'(T_RP - 1);
        end
      end
      RF_PRE: begin
        if (tcnt_q == '0) begin
          st_n   = RF_REF;
          tcnt_n = TC_W'(T_RFC - 1);
        end else begin
          tcnt_n = tcnt_q - 1'b1;
        end
      end
      default: begin
        if (tcnt_q == '0) st_n = RF_RUN;
        else              tcnt_n = tcnt_q - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q <= '0;
      due_q  <= 1'b0;
      st_q   <= RF_RUN;
      tcnt_q <= '0;
    end else begin
      rcnt_q <= rcnt_n;
      due_q  <= due_n;
      st_q   <= st_n;
      tcnt_q <= tcnt_n;
    end
  end

  assign due    = due_q;
  assign active = (st_q != RF_RUN);

  // R8
  due_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (due_q && !start) |=> due_q);

endmodule

// File: rtl/dram_rsp_arb.sv
module dram_rsp_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dram_bank_ctrl.sv
module dram_bank_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int ROW_W      = 3,
  parameter int COL_W      = 3,
  parameter int DATA_W     = 8,
  parameter int T_CAS      = 2,
  parameter int T_RCD      = 3,
  parameter int T_RP       = 3,
  parameter int T_RFC      = 4,
  parameter int REF_PERIOD = 120,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int ADDR_W    = ROW_W + BANK_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic              rsp_valid,
  output logic [BANK_W-1:0] rsp_bank,
  output logic              rsp_write,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0]  req_row;
  logic              accept;
  logic [DATA_W-1:0] acc_data;

  logic [NUM_BANKS-1:0] acc_v, busy_v, pend_v, grant_v, hit_v, wr_v;
  row_class_e           cls_v  [NUM_BANKS];
  logic [DATA_W-1:0]    data_v [NUM_BANKS];

  logic rf_due, rf_active, rf_start, rf_issue_ref, all_idle;

  cmd_op_e           cmd_op_n, cmd_op_q;
  logic [BANK_W-1:0] cmd_bank_n, cmd_bank_q;
  logic [ROW_W-1:0]  cmd_row_n, cmd_row_q;
  logic [BANK_W-1:0] rsp_idx;

  // address split: column lowest, then bank, then row
  assign req_bank = req_addr[COL_W +: BANK_W];
  assign req_row  = req_addr[COL_W + BANK_W +: ROW_W];

  assign all_idle  = ~|busy_v;
  assign req_ready = !rf_due && !rf_active && !busy_v[req_bank];
  assign accept    = req_valid && req_ready;
  assign acc_data  = req_write ? '0 : mem_rdata;

  assign mem_en    = accept;
  assign mem_we    = accept && req_write;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign acc_v[b] = accept && (req_bank == BANK_W'(b));

      dram_bank_slot #(
        .ROW_W (ROW_W),
        .DATA_W(DATA_W),
        .T_CAS (T_CAS),
        .T_RCD (T_RCD),
        .T_RP  (T_RP)
      ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc_v[b]),
        .acc_row  (req_row),
        .acc_write(req_write),
        .acc_data (acc_data),
        .close_all(rf_start),
        .grant    (grant_v[b]),
        .busy     (busy_v[b]),
        .pend     (pend_v[b]),
        .cls      (cls_v[b]),
        .hit_q    (hit_v[b]),
        .wr_q     (wr_v[b]),
        .data_q   (data_v[b])
      );
    end
  endgenerate

  dram_refresh_sched #(
    .REF_PERIOD(REF_PERIOD),
    .T_RP      (T_RP),
    .T_RFC     (T_RFC)
  ) u_refresh (
    .clk      (clk),
    .rst_n    (rst_n),
    .all_idle (all_idle),
    .due      (rf_due),
    .active   (rf_active),
    .start    (rf_start),
    .issue_ref(rf_issue_ref)
  );

  dram_rsp_arb #(.N(NUM_BANKS)) u_arb (
    .req  (pend_v),
    .grant(grant_v)
  );

  // command bus: leading command of each accepted request, refresh sequence
  always_comb begin
    cmd_op_n   = CMD_NOP;
    cmd_bank_n = '0;
    cmd_row_n  = '0;
    if (rf_start) begin
      cmd_op_n = CMD_PREA;
    end else if (rf_issue_ref) begin
      cmd_op_n = CMD_REF;
    end else if (accept) begin
      cmd_bank_n = req_bank;
      cmd_row_n  = req_row;
      case (cls_v[req_bank])
        ROW_HIT:   cmd_op_n = req_write ? CMD_WR : CMD_RD;
        ROW_EMPTY: cmd_op_n = CMD_ACT;
        default:   cmd_op_n = CMD_PRE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_op_q   <= CMD_NOP;
      cmd_bank_q <= '0;
      cmd_row_q  <= '0;
    end else begin
      cmd_op_q   <= cmd_op_n;
      cmd_bank_q <= cmd_bank_n;
      cmd_row_q  <= cmd_row_n;
    end
  end

  assign cmd_valid = (cmd_op_q != CMD_NOP);
  assign cmd_op    = cmd_op_q;
  assign cmd_bank  = cmd_bank_q;
  assign cmd_row   = cmd_row_q;

  always_comb begin
    rsp_idx = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (grant_v[b]) rsp_idx = BANK_W'(b);
    end
  end

  assign rsp_valid = |pend_v;
  assign rsp_bank  = rsp_idx;
  assign rsp_write = wr_v[rsp_idx];
  assign rsp_hit   = hit_v[rsp_idx];
  assign rsp_rdata = data_v[rsp_idx];

  // R8
  idle_during_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_active |-> (busy_v == '0));

  // R11
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_v) && (rsp_valid == (grant_v != '0)));

endmodule

// File: tb/dram_bank_ctrl_test.sv
`timescale 1ns/1ps
module dram_bank_ctrl_test;

  localparam int NB = 4, RW = 3, CW = 3, DW = 8, BW = 2, AW = RW + BW + CW;
  localparam int TCAS = 2, TRCD = 3, TRP = 3, TRFC = 4, RPER = 120;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic cmd_valid;
  logic [2:0] cmd_op;
  logic [BW-1:0] cmd_bank;
  logic [RW-1:0] cmd_row;
  logic rsp_valid, rsp_write, rsp_hit;
  logic [BW-1:0] rsp_bank;
  logic [DW-1:0] rsp_rdata;

  always #2.5 clk = ~clk;

  dram_bank_ctrl #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .DATA_W(DW),
    .T_CAS(TCAS), .T_RCD(TRCD), .T_RP(TRP), .T_RFC(TRFC), .REF_PERIOD(RPER)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .rsp_valid(rsp_valid),
    .rsp_bank(rsp_bank), .rsp_write(rsp_write), .rsp_hit(rsp_hit),
    .rsp_rdata(rsp_rdata));

  // behavioural cell array
  logic [DW-1:0] cells [0:(1<<AW)-1];
  assign mem_rdata = cells[mem_addr];
  always @(posedge clk) if (mem_en && mem_we) cells[mem_addr] <= mem_wdata;

  typedef struct { bit idle; bit wr; int addr; int data; } stim_t;
  stim_t q[$];

  int nvec = 0, nfail = 0;
  int shadow [0:(1<<AW)-1];

  // reference model state
  int m_cnt[NB], m_or[NB], m_dat[NB], m_cls[NB];
  bit m_pend[NB], m_ov[NB], m_hit[NB], m_wr[NB], m_refclosed[NB];
  int m_rc, m_tc, m_st, m_cop, m_cbank, m_crow;
  bit m_due;

  // coverage counters
  int n_acc, n_hit, n_empty, n_conf, n_overlap, n_stall, n_ref, n_after_ref;
  int n_coll, n_multi, n_rdback;

  int unsigned lfsr = 32'h1234_5678;
  function automatic int unsigned rnd();
    lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
    return lfsr;
  endfunction

  function automatic int mk(int row, int bank, int col);
    return (row << (BW + CW)) | (bank << CW) | col;
  endfunction

  task automatic push_req(bit wr, int addr, int data);
    stim_t s; s.idle = 0; s.wr = wr; s.addr = addr; s.data = data; q.push_back(s);
  endtask
  task automatic push_idle(int n);
    for (int i = 0; i < n; i++) begin
      stim_t s; s.idle = 1; s.wr = 0; s.addr = 0; s.data = 0; q.push_back(s);
    end
  endtask

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cov(string tag, string what, int cnt);
    nvec++;
    if (cnt == 0) begin
      nfail++;
      $display("FAIL %s %s never reached: actual %0d expected >0", tag, what, cnt);
    end
  endtask

  function automatic string cls_tag(int c);
    if (c == 0) return "R2";
    if (c == 1) return "R3";
    return "R4";
  endfunction

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin
      cells[i] = '0;
      shadow[i] = 0;
    end
    for (int b = 0; b < NB; b++) begin
      m_cnt[b] = 0; m_or[b] = 0; m_dat[b] = 0; m_cls[b] = 0;
      m_pend[b] = 0; m_ov[b] = 0; m_hit[b] = 0; m_wr[b] = 0; m_refclosed[b] = 0;
    end
    m_rc = 0; m_tc = 0; m_st = 0; m_cop = 0; m_cbank = 0; m_crow = 0; m_due = 0;
    n_acc = 0; n_hit = 0; n_empty = 0; n_conf = 0; n_overlap = 0; n_stall = 0;
    n_ref = 0; n_after_ref = 0; n_coll = 0; n_multi = 0; n_rdback = 0;

    // directed: empty, hit, conflict, back-read, parallel banks
    push_req(1, mk(1, 0, 2), 8'h5a);
    push_req(0, mk(1, 0, 2), 0);
    push_req(0, mk(2, 0, 2), 0);
    push_req(0, mk(1, 0, 2), 0);
    push_req(1, mk(3, 1, 0), 8'h11);
    push_req(1, mk(3, 2, 1), 8'h22);
    push_req(1, mk(3, 3, 7), 8'h33);
    push_req(0, mk(3, 1, 0), 0);
    // conflict on bank 0, then hit on bank 1 finishing on the same cycle
    push_req(0, mk(4, 0, 0), 0);
    push_idle(5);
    push_req(0, mk(3, 1, 0), 0);
    push_idle(150);
    push_req(0, mk(1, 0, 2), 0);
    // pseudo-random stream
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = rnd();
      if (r[3:0] < 3) push_idle(1 + int'(r[5:4]));
      else push_req(r[6], mk(int'(r[8:7]), int'(r[10:9]), int'(r[13:11])), int'(r[21:14]));
    end
    push_idle(60);

    // reset
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    nvec++;
    chk(req_ready == 1'b1, "R13", "req_ready in reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R13", "rsp_valid in reset", rsp_valid, 0);
    chk(cmd_valid == 1'b0, "R13", "cmd_valid in reset", cmd_valid, 0);
    chk(mem_en == 1'b0, "R13", "mem_en in reset", mem_en, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int cyc = 0; ; cyc++) begin
      bit v, ready_e, acc, all_idle, start, wrap, erv, busy_b;
      int b, row, g, npend, L, cls, ncop, ncb, ncr;
      stim_t h;
      if (cyc >= LIMIT) begin
        nfail++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, LIMIT);
        break;
      end
      if (q.size() == 0) break;
      h = q[0];
      v = !h.idle;
      req_valid = v;
      req_write = h.wr;
      req_addr  = AW'(h.addr);
      req_wdata = DW'(h.data);
      #1;
      b   = (h.addr >> CW) & (NB - 1);
      row = h.addr >> (BW + CW);
      busy_b  = (m_cnt[b] != 0) || m_pend[b];
      ready_e = !m_due && (m_st == 0) && !busy_b;
      g = -1; npend = 0;
      for (int k = NB - 1; k >= 0; k--) if (m_pend[k]) begin g = k; npend++; end
      erv = (g >= 0);
      nvec++;

      if (req_valid) begin
        string t;
        if (m_due) t = "R10"; else if (m_st != 0) t = "R8";
        else if (busy_b) t = "R7"; else t = "R6";
        chk(req_ready == ready_e, t, "req_ready", req_ready, ready_e);
      end
      chk(rsp_valid == erv, (npend > 1) ? "R11" : ((g >= 0) ? cls_tag(m_cls[g]) : "R2"),
          "rsp_valid", rsp_valid, erv);
      if (erv && rsp_valid) begin
        chk(int'(rsp_bank) == g, "R11", "rsp_bank", rsp_bank, g);
        chk(rsp_hit == m_hit[g], "R5", "rsp_hit", rsp_hit, m_hit[g]);
        chk(rsp_write == m_wr[g], "R12", "rsp_write", rsp_write, m_wr[g]);
        chk(int'(rsp_rdata) == m_dat[g], "R12", "rsp_rdata", rsp_rdata, m_dat[g]);
      end
      chk(cmd_valid == (m_cop != 0), "R8", "cmd_valid", cmd_valid, m_cop != 0);
      if (m_cop != 0) begin
        string t;
        if (m_cop >= 5) t = "R8"; else if (m_cop == 1) t = "R3";
        else if (m_cop == 4) t = "R4"; else t = "R2";
        chk(int'(cmd_op) == m_cop, t, "cmd_op", cmd_op, m_cop);
        chk(int'(cmd_bank) == m_cbank, t, "cmd_bank", cmd_bank, m_cbank);
        chk(int'(cmd_row) == m_crow, t, "cmd_row", cmd_row, m_crow);
      end
      acc = v && ready_e;
      chk(mem_en == acc, "R1", "mem_en", mem_en, acc);
      if (acc) begin
        chk(mem_we == h.wr, "R1", "mem_we", mem_we, h.wr);
        chk(int'(mem_addr) == h.addr, "R1", "mem_addr", mem_addr, h.addr);
      end

      // coverage bookkeeping
      if (npend > 1) n_multi++;
      if (v && m_due && m_st == 0 && !busy_b) n_coll++;
      if (v && !m_due && m_st == 0 && busy_b) n_stall++;

      // model step
      all_idle = 1;
      for (int k = 0; k < NB; k++) if (m_cnt[k] != 0 || m_pend[k]) all_idle = 0;
      start = (m_st == 0) && m_due && all_idle;
      ncop = 0; ncb = 0; ncr = 0;
      cls = !m_ov[b] ? 1 : ((m_or[b] == row) ? 0 : 2);
      if (start) ncop = 5;
      else if (m_st == 1 && m_tc == 0) ncop = 6;
      else if (acc) begin
        ncb = b; ncr = row;
        ncop = (cls == 0) ? (h.wr ? 3 : 2) : ((cls == 1) ? 1 : 4);
      end
      m_cop = ncop; m_cbank = ncb; m_crow = ncr;

      wrap = (m_rc == RPER - 1);
      m_rc = wrap ? 0 : m_rc + 1;
      if (m_st == 0) begin
        if (start) begin m_st = 1; m_tc = TRP - 1; n_ref++; end
      end else if (m_st == 1) begin
        if (m_tc == 0) begin m_st = 2; m_tc = TRFC - 1; end else m_tc--;
      end else begin
        if (m_tc == 0) m_st = 0; else m_tc--;
      end
      m_due = wrap ? 1'b1 : (start ? 1'b0 : m_due);

      for (int k = 0; k < NB; k++) begin
        if (start) begin
          if (m_ov[k]) m_refclosed[k] = 1;
          m_ov[k] = 0;
        end
        if (g == k) m_pend[k] = 0;
        if (m_cnt[k] != 0) begin
          if (m_cnt[k] == 1) m_pend[k] = 1;
          m_cnt[k]--;
        end
      end
      if (acc) begin
        n_acc++;
        for (int k = 0; k < NB; k++) if (k != b && (m_cnt[k] != 0 || m_pend[k])) begin
          n_overlap++; break;
        end
        if (cls == 0) n_hit++; else if (cls == 1) n_empty++; else n_conf++;
        if (m_refclosed[b]) begin n_after_ref++; m_refclosed[b] = 0; end
        L = (cls == 0) ? TCAS : ((cls == 1) ? TRCD + TCAS : TRP + TRCD + TCAS);
        if (L == 1) m_pend[b] = 1; else m_cnt[b] = L - 1;
        m_cls[b] = cls;
        m_ov[b] = 1; m_or[b] = row;
        m_hit[b] = (cls == 0); m_wr[b] = h.wr;
        m_dat[b] = h.wr ? 0 : shadow[h.addr];
        if (!h.wr && shadow[h.addr] != 0) n_rdback++;
        if (h.wr) shadow[h.addr] = h.data & 8'hff;
        void'(q.pop_front());
      end else if (h.idle) begin
        void'(q.pop_front());
      end

      @(posedge clk);
      @(negedge clk);
    end

    req_valid = 1'b0;
    cov("R1", "accepted requests", n_acc);
    cov("R2", "row hits", n_hit);
    cov("R3", "empty-bank accesses", n_empty);
    cov("R4", "row conflicts", n_conf);
    cov("R5", "hits after an earlier open", n_hit);
    cov("R6", "acceptance while another bank busy", n_overlap);
    cov("R7", "busy-bank stalls", n_stall);
    cov("R8", "refresh sequences", n_ref);
    cov("R9", "first access after refresh", n_after_ref);
    cov("R10", "refresh due against idle-bank request", n_coll);
    cov("R11", "simultaneous finished banks", n_multi);
    cov("R12", "reads of written data", n_rdback);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule